// File: doc/BRIEF.md
# Read-Burst Interruption Scheduler

This block sits on the controller side of an SDRAM interface, between the command issuer and the data pins. It follows every read burst still in flight and works out, one cycle at a time, which cycles carry read data from the memory. It also decides when the controller must raise the data mask and when it may drive write data. When a later command cuts into a burst that is still running, the block applies the rule for that kind of command. A later read takes over from its own latency onward. A write ends the read at once and masks the beats near it. A precharge lets the bus float early.

Each command is presented for one cycle with its kind, an auto-precharge flag, the CAS latency selection and the burst length selection. The command also carries the write-to-mask spacing (`ccd`) and the precharge-to-float count (`hzp`). The block accepts the command or flags it as rejected. A burst that was issued with auto-precharge cannot be interrupted. A read that would collide with write data or a masked cycle already scheduled is refused. All outputs are registered.

Top module: `rdburst_sched`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `rd_valid`, `dqm`, `dq_oe` and `reject` are all low.
- R2: An accepted read (`cmd_kind`=1) issued at edge E with latency CL (`cl_sel` 0 gives 2, 1 gives 3) and length BL (`bl_sel` 0,1,2,3 gives 1,2,4,8) raises `rd_valid` in the cycles after edges E+CL through E+CL+BL-1.
- R3: When a read interrupts a read, beats of the earlier burst that fall before the new burst's first beat are kept. Every later beat of the earlier burst is replaced by the new burst.
- R4: An accepted write (`cmd_kind`=2) issued at edge E with spacing C (`ccd` 1..3) cancels every pending read beat. `dqm` is raised in the cycles after edges E+C-1, E+C and E+C+1, but only in those of them that held a read beat.
- R5: An accepted write drives `dq_oe` for BL cycles, starting in the cycle after edge E+C+2. A later write keeps the earlier write's data cycles that come before its own start and replaces the rest.
- R6: An accepted precharge (`cmd_kind`=3) issued at edge E with count H (`hzp` 0..3) keeps read and write data cycles only up to the cycle after edge E+H-1. If the burst ends earlier on its own, the bus floats at that point.
- R7: A read, write or precharge that arrives while a burst issued with `cmd_autopre`=1 still has cycles pending after the current one raises `reject` for one cycle after its edge and has no effect.
- R8: A read whose beats would fall on a pending `dq_oe` cycle or a pending `dqm` cycle is rejected and has no effect.
- R9: `dq_oe` is never high in a cycle where `rd_valid` is high, and `dqm` is never high in a cycle where `rd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_kind | input | 2 | 0 idle, 1 read, 2 write, 3 precharge |
| cmd_autopre | input | 1 | Burst uses auto-precharge |
| cl_sel | input | 1 | CAS latency: 0 gives 2, 1 gives 3 |
| bl_sel | input | 2 | Burst length: 1, 2, 4 or 8 |
| ccd | input | 2 | Write-to-mask spacing, 1 to 3 |
| hzp | input | 2 | Precharge-to-float cycles, 0 to 3 |
| rd_valid | output | 1 | Read data expected on the bus this cycle |
| dqm | output | 1 | Data mask driven this cycle |
| dq_oe | output | 1 | Controller drives write data this cycle |
| reject | output | 1 | The command at the previous edge was refused |

## Verification
The hardest case to reach from the ports is a write that lands while read beats still fall inside its three-cycle mask window. The stimulus has to line up the read latency, the burst length and the write spacing so that the window and the beats overlap only in part. Directed sequences set up this alignment for every spacing, and also for a precharge that cuts a long burst short. Constrained random commands with mostly idle cycles then mix nested interruptions, locked auto-precharge bursts and colliding reads, and a bench reference model predicts every output in every cycle.

// File: rtl/rdsched_pkg.sv
package rdsched_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2,
    OP_PRE  = 2'd3
  } op_e;

  // burst length selection -> beat count
  function automatic logic [3:0] beats_of(input logic [1:0] sel);
    logic [3:0] n;
    case (sel)
      2'd0:    n = 4'd1;
      2'd1:    n = 4'd2;
      2'd2:    n = 4'd4;
      default: n = 4'd8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/span_mask.sv
module span_mask #(
  parameter int W  = 13,
  parameter int IW = 4
) (
  input  logic [IW-1:0] start,
  input  logic [IW-1:0] len,
  output logic [W-1:0]  mask
);
  logic [IW:0] lo;
  logic [IW:0] hi;

  assign lo = {1'b0, start};
  assign hi = {1'b0, start} + {1'b0, len};

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [IW:0] IDX = (IW+1)'(i);
    assign mask[i] = (IDX >= lo) && (IDX < hi);
  end
endmodule

// File: rtl/slot_pipe.sv
module slot_pipe #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] keep,
  input  logic [W-1:0] set,
  output logic [W-1:0] q,
  output logic [W-1:0] ahead
);
  logic [W-1:0] q_nxt;

  // slot i holds the cycle i edges ahead; shifting moves time by one
  always_comb begin
    ahead = {1'b0, q[W-1:1]};
    q_nxt = (ahead & keep) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import rdsched_pkg::*;
#(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  op_e          op,
  input  logic         autopre,
  input  logic [W-1:0] rd_ahead,
  input  logic [W-1:0] oe_ahead,
  input  logic [W-1:0] dqm_ahead,
  input  logic [W-1:0] rd_span,
  input  logic [W-1:0] wr_span,
  input  logic [W-1:0] keep_cl,
  input  logic [W-1:0] keep_wl,
  input  logic [W-1:0] keep_hz,
  input  logic [W-1:0] mask_win,
  output logic [W-1:0] rd_keep,
  output logic [W-1:0] rd_set,
  output logic [W-1:0] oe_keep,
  output logic [W-1:0] oe_set,
  output logic [W-1:0] dqm_set,
  output logic         locked,
  output logic         reject
);
  logic ap_q, ap_nxt;
  logic rej_nxt;
  logic live, clash, acc;

  always_comb begin
    locked  = ap_q && ((|rd_ahead) || (|oe_ahead));
    live    = cmd_valid && (op != OP_IDLE);
    clash   = (op == OP_RD) && (|(rd_span & (oe_ahead | dqm_ahead)));
    rej_nxt = live && (locked || clash);
    acc     = live && !rej_nxt;

    rd_keep = '1;
    rd_set  = '0;
    oe_keep = '1;
    oe_set  = '0;
    dqm_set = '0;
    ap_nxt  = ap_q;
    if (acc) begin
      case (op)
        OP_RD: begin
          rd_keep = keep_cl;
          rd_set  = rd_span;
          ap_nxt  = autopre;
        end
        OP_WR: begin
          rd_keep = '0;
          oe_keep = keep_wl;
          oe_set  = wr_span;
          dqm_set = mask_win & rd_ahead;
          ap_nxt  = autopre;
        end
        OP_PRE: begin
          rd_keep = keep_hz;
          oe_keep = keep_hz;
          ap_nxt  = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_q   <= 1'b0;
      reject <= 1'b0;
    end else begin
      ap_q   <= ap_nxt;
      reject <= rej_nxt;
    end
  end
endmodule

// File: rtl/rdburst_sched.sv
module rdburst_sched
  import rdsched_pkg::*;
#(
  parameter int MAX_CL  = 3,
  parameter int MAX_BL  = 8,
  parameter int MAX_CCD = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_kind,
  input  logic       cmd_autopre,
  input  logic       cl_sel,
  input  logic [1:0] bl_sel,
  input  logic [1:0] ccd,
  input  logic [1:0] hzp,
  output logic       rd_valid,
  output logic       dqm,
  output logic       dq_oe,
  output logic       reject
);
  localparam int WLEAD = MAX_CCD + 2;
  localparam int LEAD  = (WLEAD > MAX_CL) ? WLEAD : MAX_CL;
  localparam int DEPTH = LEAD + MAX_BL;
  localparam int IW    = $clog2(DEPTH + 1);

  op_e           op;
  logic [1:0]    ccd_e;
  logic [IW-1:0] cl_v, bl_v, wl_v, hz_v, win_v, zero_v, three_v;
  logic [DEPTH-1:0] rd_span, wr_span, keep_cl, keep_wl, keep_hz, mask_win;
  logic [DEPTH-1:0] rd_q, oe_q, dqm_q;
  logic [DEPTH-1:0] rd_ahead, oe_ahead, dqm_ahead;
  logic [DEPTH-1:0] rd_keep, rd_set, oe_keep, oe_set, dqm_set;
  logic             locked;

  always_comb begin
    op      = op_e'(cmd_kind);
    ccd_e   = (ccd == 2'd0) ? 2'd1 : ccd;
    cl_v    = cl_sel ? IW'(3) : IW'(2);
    bl_v    = IW'(beats_of(bl_sel));
    wl_v    = IW'(ccd_e) + IW'(2);
    hz_v    = IW'(hzp);
    win_v   = IW'(ccd_e) - IW'(1);
    zero_v  = '0;
    three_v = IW'(3);
  end

  span_mask #(.W(DEPTH), .IW(IW)) u_rd_span (.start(cl_v),   .len(bl_v),    .mask(rd_span));
  span_mask #(.W(DEPTH), .IW(IW)) u_wr_span (.start(wl_v),   .len(bl_v),    .mask(wr_span));
  span_mask #(.W(DEPTH), .IW(IW)) u_keep_cl (.start(zero_v), .len(cl_v),    .mask(keep_cl));
  span_mask #(.W(DEPTH), .IW(IW)) u_keep_wl (.start(zero_v), .len(wl_v),    .mask(keep_wl));
  span_mask #(.W(DEPTH), .IW(IW)) u_keep_hz (.start(zero_v), .len(hz_v),    .mask(keep_hz));
  span_mask #(.W(DEPTH), .IW(IW)) u_win     (.start(win_v),  .len(three_v), .mask(mask_win));

  intr_arbiter #(.W(DEPTH)) u_arb (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op(op), .autopre(cmd_autopre),
    .rd_ahead(rd_ahead), .oe_ahead(oe_ahead), .dqm_ahead(dqm_ahead),
    .rd_span(rd_span), .wr_span(wr_span), .keep_cl(keep_cl), .keep_wl(keep_wl),
    .keep_hz(keep_hz), .mask_win(mask_win),
    .rd_keep(rd_keep), .rd_set(rd_set), .oe_keep(oe_keep), .oe_set(oe_set),
    .dqm_set(dqm_set), .locked(locked), .reject(reject)
  );

  slot_pipe #(.W(DEPTH)) u_rd_pipe (
    .clk(clk), .rst_n(rst_n), .keep(rd_keep), .set(rd_set), .q(rd_q), .ahead(rd_ahead));
  slot_pipe #(.W(DEPTH)) u_oe_pipe (
    .clk(clk), .rst_n(rst_n), .keep(oe_keep), .set(oe_set), .q(oe_q), .ahead(oe_ahead));
  slot_pipe #(.W(DEPTH)) u_dqm_pipe (
    .clk(clk), .rst_n(rst_n), .keep({DEPTH{1'b1}}), .set(dqm_set), .q(dqm_q), .ahead(dqm_ahead));

  assign rd_valid = rd_q[0];
  assign dq_oe    = oe_q[0];
  assign dqm      = dqm_q[0];
endmodule

// File: rtl/rdburst_sched_chk.sv
module rdburst_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_kind,
  input logic       rd_valid,
  input logic       dqm,
  input logic       dq_oe,
  input logic       reject,
  input logic       locked
);
  // R9
  oe_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && dq_oe));

  // R9
  dqm_beat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqm |-> !rd_valid);

  // R7
  lock_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind != 2'd0 && locked) |=> reject);

  // R7
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> $past(cmd_valid && cmd_kind != 2'd0));

  // R4
  wr_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reject && $past(cmd_valid && cmd_kind == 2'd2)) |-> !rd_valid);
endmodule

bind rdburst_sched rdburst_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .rd_valid(rd_valid), .dqm(dqm), .dq_oe(dq_oe), .reject(reject), .locked(locked)
);

// File: tb/rdburst_sched_test.sv
`timescale 1ns/1ps
module rdburst_sched_test;
  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_kind;
  logic       cmd_autopre;
  logic       cl_sel;
  logic [1:0] bl_sel;
  logic [1:0] ccd;
  logic [1:0] hzp;
  logic       rd_valid, dqm, dq_oe, reject;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string cur_tag = "R2";

  // reference model: bit i = cycle following the i-th future edge
  bit [15:0] m_rd, m_oe, m_dqm;
  bit        m_ap;
  bit        m_rej;

  rdburst_sched uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_autopre(cmd_autopre), .cl_sel(cl_sel), .bl_sel(bl_sel), .ccd(ccd), .hzp(hzp),
    .rd_valid(rd_valid), .dqm(dqm), .dq_oe(dq_oe), .reject(reject)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit [15:0] span(input int lo, input int n);
    bit [15:0] r = '0;
    for (int i = 0; i < 16; i++) if (i >= lo && i < lo + n) r[i] = 1'b1;
    return r;
  endfunction

  function automatic int blen(input logic [1:0] s);
    return 1 << s;
  endfunction

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] k, input bit ap, input bit cs,
                      input logic [1:0] bs, input logic [1:0] cc, input logic [1:0] hz);
    bit [15:0] sr, so, sd;
    int cl, bl, ce, wl;
    bit live, lock, clash;
    cmd_valid = v; cmd_kind = k; cmd_autopre = ap; cl_sel = cs;
    bl_sel = bs; ccd = cc; hzp = hz;
    cl = cs ? 3 : 2;
    bl = blen(bs);
    ce = (cc == 0) ? 1 : int'(cc);
    wl = ce + 2;
    sr = m_rd >> 1; so = m_oe >> 1; sd = m_dqm >> 1;
    lock  = m_ap && ((sr != 0) || (so != 0));
    live  = v && (k != 2'd0);
    clash = (k == 2'd1) && ((span(cl, bl) & (so | sd)) != 0);
    m_rej = live && (lock || clash);
    if (live && !m_rej) begin
      case (k)
        2'd1: begin sr = (sr & span(0, cl)) | span(cl, bl); m_ap = ap; end
        2'd2: begin
          sd = sd | (sr & span(ce - 1, 3));
          sr = '0;
          so = (so & span(0, wl)) | span(wl, bl);
          m_ap = ap;
        end
        default: begin sr = sr & span(0, int'(hz)); so = so & span(0, int'(hz)); m_ap = 0; end
      endcase
    end
    m_rd = sr; m_oe = so; m_dqm = sd;
    @(posedge clk);
    @(negedge clk);
    check(cur_tag, "rd_valid", rd_valid, m_rd[0]);
    check("R4", "dqm", dqm, m_dqm[0]);
    check("R5", "dq_oe", dq_oe, m_oe[0]);
    check("R7", "reject", reject, m_rej);
    check("R9", "oe_rd_overlap", rd_valid && (dq_oe || dqm), 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 0, 0, 2'd0, 2'd1, 2'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cmd_valid = 0; cmd_kind = 0; cmd_autopre = 0;
    cl_sel = 0; bl_sel = 0; ccd = 2'd1; hzp = 0;
    m_rd = 0; m_oe = 0; m_dqm = 0; m_ap = 0; m_rej = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet in reset
    check("R1", "rd_valid", rd_valid, 0);
    check("R1", "dqm", dqm, 0);
    check("R1", "dq_oe", dq_oe, 0);
    check("R1", "reject", reject, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "rd_valid_post", rd_valid, 0);
    check("R1", "reject_post", reject, 0);

    // R2: plain bursts, CL2 BL4 and CL3 BL1
    cur_tag = "R2";
    step(1, 2'd1, 0, 0, 2'd2, 2'd1, 2'd0); idle(8);
    step(1, 2'd1, 0, 1, 2'd0, 2'd1, 2'd0); idle(6);

    // R3: read over read
    cur_tag = "R3";
    step(1, 2'd1, 0, 1, 2'd3, 2'd1, 2'd0); idle(2);
    step(1, 2'd1, 0, 0, 2'd1, 2'd1, 2'd0); idle(12);

    // R4: write over read, every spacing
    cur_tag = "R4";
    for (int c = 1; c <= 3; c++) begin
      step(1, 2'd1, 0, 0, 2'd3, 2'd1, 2'd0); idle(1);
      step(1, 2'd2, 0, 0, 2'd1, 2'(c), 2'd0); idle(14);
    end

    // R5: write alone, then write over write
    cur_tag = "R5";
    step(1, 2'd2, 0, 0, 2'd2, 2'd1, 2'd0); idle(10);
    step(1, 2'd2, 0, 0, 2'd3, 2'd3, 2'd0); idle(2);
    step(1, 2'd2, 0, 0, 2'd1, 2'd1, 2'd0); idle(14);

    // R6: precharge cuts a long burst; natural end beats nHZP
    cur_tag = "R6";
    step(1, 2'd1, 0, 0, 2'd3, 2'd1, 2'd0); idle(3);
    step(1, 2'd3, 0, 0, 2'd0, 2'd1, 2'd1); idle(10);
    step(1, 2'd1, 0, 0, 2'd0, 2'd1, 2'd0); idle(1);
    step(1, 2'd3, 0, 0, 2'd0, 2'd1, 2'd3); idle(6);

    // R7: auto-precharge burst locks out read, write and precharge
    cur_tag = "R7";
    step(1, 2'd1, 1, 0, 2'd3, 2'd1, 2'd0); idle(1);
    step(1, 2'd2, 0, 0, 2'd0, 2'd1, 2'd0);
    step(1, 2'd3, 0, 0, 2'd0, 2'd1, 2'd0);
    step(1, 2'd1, 0, 0, 2'd0, 2'd1, 2'd0); idle(12);

    // R8: read colliding with pending write data or mask
    cur_tag = "R8";
    step(1, 2'd2, 0, 0, 2'd2, 2'd3, 2'd0);
    step(1, 2'd1, 0, 0, 2'd2, 2'd1, 2'd0); idle(12);
    step(1, 2'd1, 0, 0, 2'd3, 2'd1, 2'd0);
    step(1, 2'd2, 0, 0, 2'd0, 2'd3, 2'd0);
    step(1, 2'd1, 0, 0, 2'd0, 2'd1, 2'd0); idle(14);

    // random mix
    cur_tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 3) == 0;
      step(v, 2'($urandom), ($urandom % 4) == 0, 1'($urandom), 2'($urandom),
           2'(1 + $urandom % 3), 2'($urandom));
    end
    idle(16);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule